// File: doc/BRIEF.md
# Bank Activation Timing Tracker

This block follows a command stream aimed at a four-bank double-data-rate memory and decides, cycle by cycle, whether the command presented on its inputs may be issued. It records which banks hold an open row and which row that is. It also times three separate windows. The first is the delay from opening a row to the first column access. The second is the minimum spacing between two row openings in the same bank. The third is the minimum spacing between row openings in different banks.

Each timing limit is a compile-time parameter that already holds a clock count. A limit specified in nanoseconds is converted by dividing it by the clock period and rounding up, so 20 ns at a 3.75 ns clock becomes 6 clocks. A column command may ask for the row to be closed automatically. In that case the bank stays busy until its burst has run out and then returns to the closed state by itself.

The command decoder of a memory controller uses the block as a legality oracle. The combinational `cmd_ok_o` answers in the same cycle. A refused command leaves every bank record untouched and raises a one-cycle `viol_o` on the following cycle.

Top module: `bank_act_tracker`

## Requirements
- R1: A synchronous reset (`srst` high at a clock edge) closes every bank and expires every timer. The first row opening to any bank after reset is legal at once, and `viol_o` reads 0.
- R2: A column command (read code 2 or write code 3) to a bank with no open row is refused.
- R3: A column command to an open bank is refused until T_RCD cycles have passed since that bank was opened, and it is legal from exactly that cycle on.
- R4: A row opening (code 1) to a bank that already has an open row is refused until the bank has been closed.
- R5: Two row openings of the same bank must be at least T_RC cycles apart. The second one is legal from exactly that distance on.
- R6: Two row openings of different banks must be at least T_RRD cycles apart. Column access to one bank does not prevent opening another.
- R7: Encoding: `cmd_i` 0 = no-op, 1 = open row, 2 = read, 3 = write, 4 = close bank. `ba_i` selects the bank. On an opening, `addr_i` carries the row. On a column command, bits 9..0 carry the column and bit 10 requests automatic close.
- R8: After an accepted column command with bit 10 set, issued in cycle c, the bank stays open through cycle c+BURST_CLKS and reads closed from cycle c+BURST_CLKS+1 on. While that close is pending, read, write, close and open commands to that bank are refused.
- R9: Without bit 10 the row stays open indefinitely. `sel_row_o` shows the stored row of the bank addressed by `ba_i`, and `bank_open_o[i]` shows whether bank i is open.
- R10: A refused command raises `viol_o` for exactly the following cycle and changes no bank state or timer.
- R11: The no-op code and the unused codes 5 to 7 are always legal, never raise `viol_o` and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state on the rising edge |
| srst | input | 1 | Synchronous reset, active high |
| cmd_i | input | 3 | Command code presented this cycle |
| ba_i | input | 2 | Bank select |
| addr_i | input | 14 | Row on an opening; column and auto-close bit on read or write |
| cmd_ok_o | output | 1 | Presented command is legal this cycle (combinational) |
| viol_o | output | 1 | Previous cycle's command was refused |
| bank_open_o | output | 4 | Per-bank open flag |
| sel_row_o | output | 14 | Stored row of the bank addressed by `ba_i` |

## Verification
The hardest situation to reach from the ports is one where several windows overlap on one bank: a pending automatic close while the same-bank spacing timer is still running, with the shared inter-bank timer belonging to another bank. The stimulus table walks a fixed command schedule in which every refusal arises at the exact boundary cycle of one limit, and the cycle just after it is accepted. Directed code then reset the block in the middle of running timers and time the automatic close cycle by cycle through `bank_open_o`.

// File: rtl/bank_trk_pkg.sv
package bank_trk_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;

  // value a down-counter is loaded with so that it reaches zero
  // exactly lim cycles after the loading edge
  function automatic int unsigned reload_of(int unsigned lim);
    return (lim == 0) ? 0 : lim - 1;
  endfunction

  // bits needed to hold reload_of(lim)
  function automatic int unsigned cnt_bits(int unsigned lim);
    return (lim < 3) ? 1 : $clog2(lim);
  endfunction

endpackage

// File: rtl/bank_state.sv
module bank_state
  import bank_trk_pkg::*;
#(
  parameter int unsigned ROW_W      = 14,
  parameter int unsigned T_RCD      = 3,
  parameter int unsigned T_RC       = 8,
  parameter int unsigned BURST_CLKS = 4
) (
  input  logic             clk,
  input  logic             srst,
  input  logic             act_go,
  input  logic             acc_go,
  input  logic             ap_go,
  input  logic             pre_go,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             rcd_done_o,
  output logic             rc_done_o,
  output logic             ap_busy_o,
  output logic             ap_close_o
);

  localparam int unsigned RCD_W = cnt_bits(T_RCD);
  localparam int unsigned RC_W  = cnt_bits(T_RC);
  localparam int unsigned AP_W  = cnt_bits(BURST_CLKS);
  localparam logic [RCD_W-1:0] RCD_LD = RCD_W'(reload_of(T_RCD));
  localparam logic [RC_W-1:0]  RC_LD  = RC_W'(reload_of(T_RC));
  localparam logic [AP_W-1:0]  AP_LD  = AP_W'(reload_of(BURST_CLKS));

  logic             open_q;
  logic [ROW_W-1:0] row_q;
  logic [RCD_W-1:0] rcd_q;
  logic [RC_W-1:0]  rc_q;
  logic [AP_W-1:0]  ap_q;
  logic             busy_q;

  assign ap_close_o = busy_q && (ap_q == '0);
  assign open_o     = open_q;
  assign row_o      = row_q;
  assign rcd_done_o = (rcd_q == '0);
  assign rc_done_o  = (rc_q == '0);
  assign ap_busy_o  = busy_q;

  always_ff @(posedge clk) begin
    if (srst) begin
      open_q <= 1'b0;
      row_q  <= '0;
      rcd_q  <= '0;
      rc_q   <= '0;
      ap_q   <= '0;
      busy_q <= 1'b0;
    end else begin
      if (act_go) begin
        open_q <= 1'b1;
        row_q  <= row_i;
        rcd_q  <= RCD_LD;
        rc_q   <= RC_LD;
      end else begin
        if (rcd_q != '0) rcd_q <= rcd_q - 1'b1;
        if (rc_q != '0)  rc_q  <= rc_q - 1'b1;
      end
      if (pre_go) open_q <= 1'b0;
      if (acc_go && ap_go) begin
        busy_q <= 1'b1;
        ap_q   <= AP_LD;
      end else if (busy_q) begin
        if (ap_q == '0) begin
          busy_q <= 1'b0;
          open_q <= 1'b0;
        end else begin
          ap_q <= ap_q - 1'b1;
        end
      end
    end
  end

  // R9
  open_row_chk: assert property (@(posedge clk) disable iff (srst)
    act_go |=> (open_o && row_o == $past(row_i)));

  // R8
  ap_close_chk: assert property (@(posedge clk) disable iff (srst)
    ap_close_o |=> (!open_o && !ap_busy_o));

  if (T_RC > 1) begin : g_rc_chk
    // R5
    rc_hold_chk: assert property (@(posedge clk) disable iff (srst)
      act_go |=> !rc_done_o);
  end

  if (T_RCD > 1) begin : g_rcd_chk
    // R3
    rcd_hold_chk: assert property (@(posedge clk) disable iff (srst)
      act_go |=> !rcd_done_o);
  end

endmodule

// File: rtl/act_spacing.sv
module act_spacing
  import bank_trk_pkg::*;
#(
  parameter int unsigned BA_W  = 2,
  parameter int unsigned T_RRD = 2
) (
  input  logic            clk,
  input  logic            srst,
  input  logic            act_go,
  input  logic [BA_W-1:0] ba_i,
  output logic            rrd_ok_o
);

  localparam int unsigned RRD_W = cnt_bits(T_RRD);
  localparam logic [RRD_W-1:0] RRD_LD = RRD_W'(reload_of(T_RRD));

  logic [RRD_W-1:0] cnt_q;
  logic [BA_W-1:0]  last_q;
  logic             rrd_free;

  assign rrd_free = (cnt_q == '0);
  // the inter-bank spacing does not bind a repeat to the same bank
  assign rrd_ok_o = rrd_free || (ba_i == last_q);

  always_ff @(posedge clk) begin
    if (srst) begin
      cnt_q  <= '0;
      last_q <= '0;
    end else if (act_go) begin
      cnt_q  <= RRD_LD;
      last_q <= ba_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  if (T_RRD > 1) begin : g_rrd_chk
    // R6
    rrd_hold_chk: assert property (@(posedge clk) disable iff (srst)
      act_go |=> !rrd_free);
  end

endmodule

// File: rtl/cmd_judge.sv
module cmd_judge
  import bank_trk_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned BA_W      = 2
) (
  input  logic [2:0]           cmd_i,
  input  logic [BA_W-1:0]      ba_i,
  input  logic                 ap_i,
  input  logic [NUM_BANKS-1:0] open_i,
  input  logic [NUM_BANKS-1:0] rcd_done_i,
  input  logic [NUM_BANKS-1:0] rc_done_i,
  input  logic [NUM_BANKS-1:0] ap_busy_i,
  input  logic                 rrd_ok_i,
  output logic                 ok_o,
  output logic                 illegal_o,
  output logic                 ap_go_o,
  output logic [NUM_BANKS-1:0] act_go_o,
  output logic [NUM_BANKS-1:0] acc_go_o,
  output logic [NUM_BANKS-1:0] pre_go_o
);

  logic is_act, is_col, is_pre, is_real;
  logic sel_open, sel_rcd, sel_rc, sel_busy;

  assign is_act  = (cmd_i == CMD_ACT);
  assign is_col  = (cmd_i == CMD_RD) || (cmd_i == CMD_WR);
  assign is_pre  = (cmd_i == CMD_PRE);
  assign is_real = is_act || is_col || is_pre;

  assign sel_open = open_i[ba_i];
  assign sel_rcd  = rcd_done_i[ba_i];
  assign sel_rc   = rc_done_i[ba_i];
  assign sel_busy = ap_busy_i[ba_i];

  always_comb begin
    if (is_act)      ok_o = !sel_open && sel_rc && rrd_ok_i;
    else if (is_col) ok_o = sel_open && sel_rcd && !sel_busy;
    else if (is_pre) ok_o = !sel_busy;
    else             ok_o = 1'b1;
  end

  assign illegal_o = is_real && !ok_o;
  assign ap_go_o   = is_col && ap_i;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_go
    logic hit;
    assign hit         = ok_o && (ba_i == BA_W'(b));
    assign act_go_o[b] = hit && is_act;
    assign acc_go_o[b] = hit && is_col;
    assign pre_go_o[b] = hit && is_pre;
  end

endmodule

// File: rtl/bank_act_tracker.sv
module bank_act_tracker
  import bank_trk_pkg::*;
#(
  parameter int unsigned NUM_BANKS  = 4,
  parameter int unsigned ADDR_W     = 14,
  parameter int unsigned AP_BIT     = 10,
  parameter int unsigned T_RCD      = 3,
  parameter int unsigned T_RC       = 8,
  parameter int unsigned T_RRD      = 2,
  parameter int unsigned BURST_CLKS = 4
) (
  input  logic                      clk,
  input  logic                      srst,
  input  logic [2:0]                cmd_i,
  input  logic [$clog2(NUM_BANKS)-1:0] ba_i,
  input  logic [ADDR_W-1:0]         addr_i,
  output logic                      cmd_ok_o,
  output logic                      viol_o,
  output logic [NUM_BANKS-1:0]      bank_open_o,
  output logic [ADDR_W-1:0]         sel_row_o
);

  localparam int unsigned BA_W = $clog2(NUM_BANKS);

  logic [NUM_BANKS-1:0] open_v, rcd_v, rc_v, busy_v, close_v;
  logic [NUM_BANKS-1:0] act_go_v, acc_go_v, pre_go_v;
  logic [ADDR_W-1:0]    row_v [NUM_BANKS];
  logic                 ap_go, rrd_ok, illegal, viol_q;

  cmd_judge #(.NUM_BANKS(NUM_BANKS), .BA_W(BA_W)) judge_i (
    .cmd_i      (cmd_i),
    .ba_i       (ba_i),
    .ap_i       (addr_i[AP_BIT]),
    .open_i     (open_v),
    .rcd_done_i (rcd_v),
    .rc_done_i  (rc_v),
    .ap_busy_i  (busy_v),
    .rrd_ok_i   (rrd_ok),
    .ok_o       (cmd_ok_o),
    .illegal_o  (illegal),
    .ap_go_o    (ap_go),
    .act_go_o   (act_go_v),
    .acc_go_o   (acc_go_v),
    .pre_go_o   (pre_go_v)
  );

  act_spacing #(.BA_W(BA_W), .T_RRD(T_RRD)) spacing_i (
    .clk      (clk),
    .srst     (srst),
    .act_go   (|act_go_v),
    .ba_i     (ba_i),
    .rrd_ok_o (rrd_ok)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bank_state #(
      .ROW_W(ADDR_W), .T_RCD(T_RCD), .T_RC(T_RC), .BURST_CLKS(BURST_CLKS)
    ) bank_i (
      .clk        (clk),
      .srst       (srst),
      .act_go     (act_go_v[b]),
      .acc_go     (acc_go_v[b]),
      .ap_go      (ap_go),
      .pre_go     (pre_go_v[b]),
      .row_i      (addr_i),
      .open_o     (open_v[b]),
      .row_o      (row_v[b]),
      .rcd_done_o (rcd_v[b]),
      .rc_done_o  (rc_v[b]),
      .ap_busy_o  (busy_v[b]),
      .ap_close_o (close_v[b])
    );
  end

  always_ff @(posedge clk) begin
    if (srst) viol_q <= 1'b0;
    else      viol_q <= illegal;
  end

  assign viol_o      = viol_q;
  assign bank_open_o = open_v;
  assign sel_row_o   = row_v[ba_i];

  // R2
  col_needs_open_chk: assert property (@(posedge clk) disable iff (srst)
    (cmd_ok_o && (cmd_i == CMD_RD || cmd_i == CMD_WR)) |-> bank_open_o[ba_i]);

  // R10
  viol_pulse_chk: assert property (@(posedge clk) disable iff (srst)
    viol_o |-> $past(cmd_i != CMD_NOP && !cmd_ok_o));

  // R10
  refused_keeps_open_chk: assert property (@(posedge clk) disable iff (srst)
    (illegal && close_v == '0) |=> $stable(bank_open_o));

  // R11
  nop_always_ok_chk: assert property (@(posedge clk) disable iff (srst)
    (cmd_i == CMD_NOP) |-> cmd_ok_o);

  // R4
  one_act_per_cycle_chk: assert property (@(posedge clk) disable iff (srst)
    $onehot0(act_go_v | acc_go_v | pre_go_v));

endmodule

// File: tb/bank_act_tracker_tb_top.sv
`timescale 1ns/1ps
module bank_act_tracker_tb_top;

  localparam int T_RCD = 3;
  localparam int T_RC  = 8;
  localparam int T_RRD = 2;
  localparam int BURST = 4;
  localparam int NV    = 18;

  localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2,
                         C_WR = 3'd3, C_PRE = 3'd4;
  localparam logic [13:0] AP = 14'h0400;

  // {req[23:20], cmd[19:17], ba[16:15], addr[14:1], expect_ok[0]}
  localparam logic [23:0] VEC [NV] = '{
    {4'd1,  C_ACT, 2'd0, 14'd5,   1'b1},  // R1 first open after reset
    {4'd3,  C_RD,  2'd0, 14'd0,   1'b0},  // R3 one cycle after open
    {4'd6,  C_ACT, 2'd1, 14'd7,   1'b1},  // R6 other bank at exact spacing
    {4'd6,  C_ACT, 2'd2, 14'd9,   1'b0},  // R6 one cycle too early
    {4'd3,  C_RD,  2'd1, 14'd3,   1'b0},  // R3 two cycles after open
    {4'd3,  C_RD,  2'd1, 14'd3,   1'b1},  // R3 exact delay, no auto close
    {4'd7,  C_PRE, 2'd0, 14'd0,   1'b1},  // R7 close bank 0
    {4'd5,  C_ACT, 2'd0, 14'd3,   1'b0},  // R5 seven cycles after last open
    {4'd5,  C_ACT, 2'd0, 14'd3,   1'b1},  // R5 exact spacing
    {4'd2,  C_RD,  2'd2, 14'd0,   1'b0},  // R2 bank 2 never opened
    {4'd4,  C_ACT, 2'd1, 14'd8,   1'b0},  // R4 bank 1 still open
    {4'd8,  C_WR,  2'd0, AP,      1'b1},  // R8 write with auto close
    {4'd8,  C_RD,  2'd0, 14'd0,   1'b0},  // R8 close pending
    {4'd8,  C_PRE, 2'd0, 14'd0,   1'b0},  // R8 close pending
    {4'd11, C_NOP, 2'd0, 14'd0,   1'b1},  // R11 no-op
    {4'd8,  C_ACT, 2'd0, 14'd11,  1'b0},  // R8 not yet closed
    {4'd8,  C_ACT, 2'd0, 14'd11,  1'b1},  // R8 closed after burst
    {4'd11, 3'd7,  2'd2, 14'd0,   1'b1}   // R11 unused code
  };

  logic        clk = 1'b0;
  logic        srst = 1'b1;
  logic [2:0]  cmd = 3'd0;
  logic [1:0]  ba = 2'd0;
  logic [13:0] addr = 14'd0;
  logic        cmd_ok, viol;
  logic [3:0]  bank_open;
  logic [13:0] sel_row;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bank_act_tracker #(
    .NUM_BANKS(4), .ADDR_W(14), .AP_BIT(10),
    .T_RCD(T_RCD), .T_RC(T_RC), .T_RRD(T_RRD), .BURST_CLKS(BURST)
  ) dut_i (
    .clk(clk), .srst(srst), .cmd_i(cmd), .ba_i(ba), .addr_i(addr),
    .cmd_ok_o(cmd_ok), .viol_o(viol), .bank_open_o(bank_open),
    .sel_row_o(sel_row)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // one cycle: drive at the falling edge, judge before the rising edge,
  // look at the violation flag after it
  task automatic issue(logic [2:0] c, logic [1:0] b, logic [13:0] a,
                       logic exp_ok, string req);
    logic real_cmd;
    real_cmd = (c >= 3'd1) && (c <= 3'd4);
    @(negedge clk);
    cmd = c; ba = b; addr = a;
    #1;
    chk({req, " ok"}, int'(cmd_ok), int'(exp_ok));
    @(posedge clk);
    #1;
    chk({req, " viol"}, int'(viol), int'(real_cmd && !exp_ok));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    srst = 1'b0;
    #1;
    // R1 reset state
    chk("R1 open after reset", int'(bank_open), 0);
    chk("R1 viol after reset", int'(viol), 0);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][19:17], VEC[i][16:15], VEC[i][14:1], VEC[i][0],
            $sformatf("R%0d vec%0d", VEC[i][23:20], i));
    end

    // R9 stored rows and rows left open without auto close
    issue(C_NOP, 2'd1, 14'd0, 1'b1, "R9 nop");
    chk("R9 row of bank 1", int'(sel_row), 7);
    issue(C_NOP, 2'd0, 14'd0, 1'b1, "R9 nop");
    chk("R9 row of bank 0", int'(sel_row), 11);
    chk("R9 open flags", int'(bank_open), 3);

    // R1 reset in the middle of running timers
    @(negedge clk);
    cmd = C_NOP;
    srst = 1'b1;
    @(posedge clk);
    #1;
    chk("R1 closed after mid reset", int'(bank_open), 0);
    @(negedge clk);
    srst = 1'b0;
    issue(C_ACT, 2'd0, 14'd20, 1'b1, "R1 open right after reset");

    // R8 exact timing of the automatic close
    issue(C_NOP, 2'd0, 14'd0, 1'b1, "R11 idle");
    issue(C_NOP, 2'd0, 14'd0, 1'b1, "R11 idle");
    issue(C_RD, 2'd0, AP, 1'b1, "R8 read with auto close");
    for (int k = 1; k <= BURST + 1; k++) begin
      if (k > 1) issue(C_NOP, 2'd0, 14'd0, 1'b1, "R11 idle");
      chk($sformatf("R8 open %0d after", k), int'(bank_open[0]),
          int'(k <= BURST));
    end
    issue(C_ACT, 2'd0, 14'd21, 1'b1, "R8 reopen after close");
    chk("R9 reopened row", int'(sel_row), 21);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule